// File: doc/BRIEF.md
# Dual-Stage 64-bit Whitening Combiner

This block post-processes a stream of 32-bit words taken from a chaotic-map source and turns each accepted word into a 64-bit pseudo-random word. The raw word passes through two mixing stages in series, and both stages have the same structure. The second stage mixes the first stage's result again. A keyed output rotator then merges the two 32-bit results into one 64-bit word. The design therefore emits twice as many bits per cycle as the source supplies.

Each mixing stage does two things. It first rotates its input word left by its own 5-bit key. It then runs a bit-serial XNOR chain from the least significant bit upwards, and this chain is seeded by a single key bit. Both stages use the same seed bit. All keys and the seed are captured in the same cycle as the word they belong to. Every stage is registered.

Top module: `dual_whiten_64`

## Requirements
- R1: Synchronous active-low reset. On the first falling clock edge after reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high immediately after the third rising clock edge, counting the edge that samples `in_valid` high. It is low after the third edge that samples `in_valid` low.
- R3: The first stage rotates `in_word` left by `key_a` to give p. It then forms c[0] = p[0] XOR `in_seed` and c[i] = NOT(c[i-1] XOR p[i]) for i = 1..31. The stage result is c.
- R4: The second stage applies the R3 function to the first stage's result. It uses `key_b` and the same `in_seed`.
- R5: `out_data` equals the 64-bit value {second-stage result, first-stage result} rotated left by 2×`key_out`. The rotate amount therefore ranges from 0 to 62.
- R6: All keys and the seed are sampled in the same cycle as the word. If they change in later cycles, results already accepted keep their values.
- R7: While no valid result is being emitted, `out_data` holds the last valid result. A cycle with `in_valid` low does not change any pipeline contents.
- R8: Back-to-back valid inputs give one new 64-bit result on every cycle, with no bubbles.
- R9: The key extremes 0 and 31 behave as R3 and R5 define. For example, with a zero word, zero seed and all keys 0, the output is 64'hCCCCCCCC_AAAAAAAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` and the keys as valid this cycle |
| in_word | input | 32 | Source word from the chaotic generator |
| in_seed | input | 1 | Chain seed bit used by both stages |
| key_a | input | 5 | Rotate key of the first stage |
| key_b | input | 5 | Rotate key of the second stage |
| key_out | input | 5 | Output rotation key (rotates by twice this value) |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Whitened 64-bit result |

## Verification
A word sampled at rising edge N produces its result after edge N+2. The bench samples on the falling edge that follows edge N+2, and it makes both the valid and the data checks at that point. The bench's reference model is a queue that is three deep. The model pushes the expected result at each rising edge and pops the oldest entry at each falling edge. Because the model computes the expected value from the keys driven with the word, any later change to the keys (R6) or any idle gap (R7) must leave the popped value unchanged.

// File: rtl/dw_pkg.sv
// Shared sizing for the whitening combiner.
// Assumes the key width addresses every bit position of a word (2**KEY_W == WORD_W).
package dw_pkg;
    parameter int WORD_W = 32;
    parameter int KEY_W  = 5;
    parameter int OUT_W  = 2 * WORD_W;
endpackage

// File: rtl/whiten_stage.sv
// One mixing stage: rotates the word left by the key, then runs an XNOR chain
// from bit 0 upward, seeded by a single bit. The result is registered.
// A sideband bus is carried alongside the word so that keys travel with it.
// Assumes KW bits can express any rotate amount below W.
module whiten_stage #(
    parameter int W  = dw_pkg::WORD_W,
    parameter int KW = dw_pkg::KEY_W,
    parameter int SW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [W-1:0]  in_word,
    input  logic [KW-1:0] in_key,
    input  logic          in_seed,
    input  logic [SW-1:0] in_side,
    output logic          out_vld,
    output logic [W-1:0]  out_word,
    output logic [SW-1:0] out_side
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dbl;
    logic [W-1:0]  perm;
    logic [W-1:0]  chain;

    // Rotate left by the key using a doubled word.
    always_comb begin
        dbl  = {in_word, in_word} << in_key;
        perm = dbl[DW-1:W];
    end

    // Seeded bit-serial chain: bit 0 is XOR, the remaining bits are XNOR.
    assign chain[0] = perm[0] ^ in_seed;
    generate
        for (genvar i = 1; i < W; i++) begin : g_chain
            assign chain[i] = ~(chain[i-1] ^ perm[i]);
        end
    endgenerate

    // Pipeline register: valid always advances, data loads only when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_word <= '0;
            out_side <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_word <= chain;
                out_side <= in_side;
            end
        end
    end

    a_r2_stage_vld_on: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r2_stage_vld_off: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r7_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_word) && $stable(out_side)));
    // R3: each chain link toggles exactly where the permuted bit is 0, so the
    // weight of the neighbour differences follows from the input weight.
    a_r3_chain_weight: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ($countones(out_word ^ {out_word[W-2:0], $past(in_seed)})
                    == (W - 1) - $past($countones(in_word)) + 2 * $past(int'(perm[0]))));
endmodule

// File: rtl/out_rotate.sv
// Output merge: concatenates {hi, lo} and rotates the 64-bit value left by
// twice the key. The result is registered and held while input is not valid.
// Assumes 2*(2**KW - 1) is smaller than the merged width.
module out_rotate #(
    parameter int W  = dw_pkg::WORD_W,
    parameter int KW = dw_pkg::KEY_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [W-1:0]    in_hi,
    input  logic [W-1:0]    in_lo,
    input  logic [KW-1:0]   in_key,
    output logic            out_vld,
    output logic [2*W-1:0]  out_data
);
    localparam int MW = 2 * W;

    logic [KW:0]     amt;
    logic [MW-1:0]   cat;
    logic [2*MW-1:0] dbl;
    logic [MW-1:0]   rot;

    // Even rotate amount, then a left rotate through a doubled vector.
    always_comb begin
        amt = {in_key, 1'b0};
        cat = {in_hi, in_lo};
        dbl = {cat, cat} << amt;
        rot = dbl[2*MW-1:MW];
    end

    // Output register: loads on valid, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_data <= rot;
            end
        end
    end

    a_r5_rot_weight: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ($countones(out_data) == $past($countones({in_hi, in_lo}))));
    a_r2_out_vld: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_data));
endmodule

// File: rtl/dual_whiten_64.sv
// Top: two mixing stages in series followed by the keyed output rotator.
// Keys and the seed are captured with each word and carried down the pipe.
// The fixed latency is three registers. Assumes upstream holds no backpressure.
module dual_whiten_64 #(
    parameter int WORD_W = dw_pkg::WORD_W,
    parameter int KEY_W  = dw_pkg::KEY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                in_seed,
    input  logic [KEY_W-1:0]    key_a,
    input  logic [KEY_W-1:0]    key_b,
    input  logic [KEY_W-1:0]    key_out,
    output logic                out_valid,
    output logic [2*WORD_W-1:0] out_data
);
    localparam int S1_SW = 2 * KEY_W + 1;
    localparam int S2_SW = KEY_W + WORD_W;

    logic              s1_vld;
    logic [WORD_W-1:0] s1_word;
    logic [S1_SW-1:0]  s1_side;
    logic              s2_vld;
    logic [WORD_W-1:0] s2_word;
    logic [S2_SW-1:0]  s2_side;

    // The first stage carries {key_out, key_b, seed} forward.
    whiten_stage #(.W(WORD_W), .KW(KEY_W), .SW(S1_SW)) u_stage1 (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_valid), .in_word(in_word), .in_key(key_a), .in_seed(in_seed),
        .in_side({key_out, key_b, in_seed}),
        .out_vld(s1_vld), .out_word(s1_word), .out_side(s1_side)
    );

    // The second stage reuses the seed and carries {key_out, stage-1 word}.
    whiten_stage #(.W(WORD_W), .KW(KEY_W), .SW(S2_SW)) u_stage2 (
        .clk(clk), .rst_n(rst_n),
        .in_vld(s1_vld), .in_word(s1_word), .in_key(s1_side[KEY_W:1]),
        .in_seed(s1_side[0]),
        .in_side({s1_side[S1_SW-1:KEY_W+1], s1_word}),
        .out_vld(s2_vld), .out_word(s2_word), .out_side(s2_side)
    );

    // Merge {stage2, stage1} and apply the output rotation.
    out_rotate #(.W(WORD_W), .KW(KEY_W)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .in_vld(s2_vld), .in_hi(s2_word), .in_lo(s2_side[WORD_W-1:0]),
        .in_key(s2_side[S2_SW-1:WORD_W]),
        .out_vld(out_valid), .out_data(out_data)
    );

    a_r8_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && s1_vld && s2_vld) |=> (out_valid && s1_vld && s2_vld));
endmodule

// File: tb/dual_whiten_64_bench.sv
module dual_whiten_64_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_seed = 1'b0;
    logic [4:0]  key_a = '0, key_b = '0, key_out = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic        q_v[$];
    logic [63:0] q_d[$];
    logic        m_v;
    logic [63:0] m_d;

    always #4 clk = ~clk;

    dual_whiten_64 u_dual_whiten_64 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_seed(in_seed), .key_a(key_a), .key_b(key_b), .key_out(key_out),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] mix(input logic [31:0] w, input int k, input logic s);
        logic [31:0] p, c;
        for (int i = 0; i < 32; i++) p[(i + k) % 32] = w[i];
        for (int i = 0; i < 32; i++) begin
            if (i == 0) c[0] = p[0] ^ s;
            else        c[i] = ~(c[i-1] ^ p[i]);
        end
        return c;
    endfunction

    function automatic logic [63:0] expect_out(input logic [31:0] w, input int ka,
                                               input int kb, input int ko, input logic s);
        logic [31:0] a, b;
        logic [63:0] cat, r;
        a   = mix(w, ka, s);
        b   = mix(a, kb, s);
        cat = {b, a};
        for (int i = 0; i < 64; i++) r[(i + 2 * ko) % 64] = cat[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, let the model take the edge, then compare at the falling edge.
    task automatic cycle(input string tag, input logic v, input logic [31:0] w,
                         input int ka, input int kb, input int ko, input logic s);
        in_valid = v; in_word = w; key_a = 5'(ka); key_b = 5'(kb); key_out = 5'(ko);
        in_seed = s;
        @(posedge clk);
        q_v.push_back(v);
        q_d.push_back(v ? expect_out(w, ka, kb, ko, s) : 64'h0);
        @(negedge clk);
        if (q_v.size() > 2) begin
            logic pv;
            logic [63:0] pd;
            pv = q_v.pop_front();
            pd = q_d.pop_front();
            m_v = pv;
            if (pv) m_d = pd;
            check({"R2 valid ", tag}, {63'h0, out_valid}, {63'h0, m_v});
            check(tag, out_data, m_d);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        m_v = 0; m_d = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset data", out_data, 64'h0);
        q_v.push_back(0); q_d.push_back(0);
        q_v.push_back(0); q_d.push_back(0);

        // R9/R3/R4: known constant with zero inputs and zero keys
        cycle("R9 zero", 1, 32'h0, 0, 0, 0, 0);
        repeat (2) cycle("R9 zero", 0, 32'h0, 0, 0, 0, 0);
        check("R3 R4 R9 constant", out_data, 64'hCCCCCCCC_AAAAAAAA);

        // R9: maximum keys with the seed set
        cycle("R9 max keys", 1, 32'h8000_0001, 31, 31, 31, 1);
        cycle("R9 max keys", 1, 32'hFFFF_FFFF, 31, 0, 31, 0);
        repeat (3) cycle("R9 drain", 0, 32'h0, 0, 0, 0, 0);

        // R6: keys change on idle cycles right after a word is accepted
        cycle("R6 key sample", 1, 32'h1234_5678, 3, 17, 9, 1);
        cycle("R6 key sample", 0, 32'hDEAD_BEEF, 30, 1, 22, 0);
        cycle("R6 key sample", 0, 32'h0BAD_F00D, 12, 5, 14, 1);
        cycle("R6 key sample", 0, 32'h0, 0, 0, 0, 0);

        // R3 R4 R5 R8: back-to-back random stream with keys changing each word
        for (int i = 0; i < 300; i++)
            cycle("R8 stream R5", 1, $urandom, $urandom_range(0, 31), $urandom_range(0, 31),
                  $urandom_range(0, 31), 1'($urandom));

        // R7: sparse valid, output holds during gaps
        for (int i = 0; i < 300; i++)
            cycle("R7 sparse", ($urandom_range(0, 3) == 0), $urandom, $urandom_range(0, 31),
                  $urandom_range(0, 31), $urandom_range(0, 31), 1'($urandom));
        repeat (4) cycle("R7 idle hold", 0, $urandom, $urandom_range(0, 31), 1, 2, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule